// File: doc/BRIEF.md
# Unnormalized-to-interval converter

This unit moves a floating-point value between two views of its accuracy. In the first view, a single unnormalized number carries its precision in its leading zeros: the fewer mantissa bits it has, the less is known about it. In the second view, the same knowledge is a closed interval given by two normalized bounds. The unit turns one view into the other in either direction, one operation per accepted request.

In the expand direction, one operand arrives and the unit produces a pair. The lower bound is the operand shifted up to normal form with zeros entering at the bottom. The upper bound uses the same shift with ones entering at the bottom. The pair is meant for an even-numbered register and the register after it, with the lower bound in the even one. In the collapse direction, a bound pair arrives and the unit produces the unnormalized number that encloses both bounds as tightly as possible. It finds how many leading mantissa bits the bounds share, keeps only those bits and raises the exponent by the number of bits dropped. Bounds given in the wrong order raise an error flag.

Words use this layout: bit 32 is the sign, bits 31:24 are an excess-128 exponent and bits 23:0 are an explicit mantissa. Exponent and mantissa widths are parameters. Each result is registered, so it appears one clock after the request.

Top module: `unorm_interval_conv`

## Requirements
- R1: Expand (`req_op`=0): `res_lo` keeps the sign of `req_word`. Its mantissa is the input mantissa shifted left by its leading-zero count, or by the exponent if that is smaller. Zeros fill the vacated low bits, and the exponent drops by the shift amount.
- R2: Expand: `res_hi` has the same sign, exponent and shift as `res_lo`, but every vacated low mantissa bit is 1.
- R3: Expand of a zero mantissa gives all-zero words on both `res_lo` and `res_hi`, whatever the sign and exponent. No fill is applied.
- R4: Collapse (`req_op`=1), with bounds of the same sign and the same exponent after normalization: let k be the number of leading mantissa bits the two bounds share. The result mantissa is the lower bound's mantissa shifted right by 24-k. The exponent is the common exponent plus 24-k, and the sign is the common sign.
- R5: Collapse of two identical bounds returns the normalized bound unchanged. Collapse of two zero bounds returns an all-zero word.
- R6: Collapse with bounds of different signs gives sign 0, the larger normalized exponent and a zero mantissa. With the same sign but different normalized exponents, it gives that sign, the larger exponent and a zero mantissa.
- R7: Collapse with bounds of the same sign where the first bound has the larger magnitude (normalized exponent:mantissa compared) sets `res_err` and gives an all-zero result.
- R8: Collapse whose raised exponent would pass 255 gives the common sign, exponent 255 and a zero mantissa.
- R9: `res_valid` rises exactly one clock after each accepted `req_valid` and is low otherwise. In collapse, `res_hi` is zero. In expand, `res_err` is 0. Outputs are all zero after reset and hold between requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one operation per cycle |
| req_op | input | 1 | 0 = expand to interval, 1 = collapse to unnormalized |
| req_word | input | 33 | Unnormalized operand for expand |
| req_lo | input | 33 | First (smaller-magnitude) bound for collapse |
| req_hi | input | 33 | Second bound for collapse |
| res_valid | output | 1 | Result strobe |
| res_lo | output | 33 | Lower bound (expand) or collapsed number (collapse) |
| res_hi | output | 33 | Upper bound (expand), zero in collapse |
| res_err | output | 1 | Bound order error in collapse |

## Verification
A fault in the leading-zero count or the shift clamp shows up at the ports. It gives a wrong exponent on both bounds and an upper bound whose one-fill does not match the lower bound. Either error is visible on the first `res_valid` after the faulty request. A fault in the shared-prefix search gives a collapsed word whose exponent and mantissa disagree about the dropped bit count, also one clock after the request. Each of these is seen on every cycle by comparing against a behavioural model. An ordering or overflow fault appears as a wrong `res_err` or a wrong saturated word on the same result cycle.

// File: rtl/unint_pkg.sv
package unint_pkg;
   typedef enum logic {
      OP_EXPAND   = 1'b0,
      OP_COLLAPSE = 1'b1
   } unint_op_e;
endpackage

// File: rtl/unint_lzc.sv
module unint_lzc #(
   parameter  int W  = 24,
   localparam int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec_i,
   output logic [CW-1:0] cnt_o
);
   if (W < 2) begin : g_bad_w
      $error("unint_lzc: W must be at least 2");
   end

   always_comb begin
      cnt_o = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (vec_i[i]) cnt_o = CW'(W - 1 - i);
      end
   end
endmodule

// File: rtl/unint_norm.sv
module unint_norm #(
   parameter  int EXP_W = 8,
   parameter  int MAN_W = 24,
   localparam int CW    = $clog2(MAN_W + 1)
) (
   input  logic [EXP_W-1:0] exp_i,
   input  logic [MAN_W-1:0] man_i,
   input  logic             fill_i,
   output logic [EXP_W-1:0] exp_o,
   output logic [MAN_W-1:0] man_o,
   output logic             zero_o
);
   logic [CW-1:0]    lz;
   logic [CW-1:0]    sh;
   logic [MAN_W-1:0] low_mask;

   unint_lzc #(.W(MAN_W)) u_lzc (.vec_i(man_i), .cnt_o(lz));

   assign zero_o = (man_i == '0);

   always_comb begin
      if (int'(lz) > int'(exp_i)) sh = CW'(exp_i);
      else                        sh = lz;
      low_mask = ~({MAN_W{1'b1}} << sh);
      if (zero_o) begin
         exp_o = '0;
         man_o = '0;
      end else begin
         exp_o = exp_i - EXP_W'(sh);
         man_o = (man_i << sh) | (fill_i ? low_mask : '0);
      end
   end
endmodule

// File: rtl/unint_enclose.sv
module unint_enclose #(
   parameter  int EXP_W = 8,
   parameter  int MAN_W = 24,
   localparam int W     = 1 + EXP_W + MAN_W,
   localparam int CW    = $clog2(MAN_W + 1),
   localparam int EMAX  = (1 << EXP_W) - 1
) (
   input  logic [W-1:0] lo_i,
   input  logic [W-1:0] hi_i,
   output logic [W-1:0] res_o,
   output logic         err_o
);
   logic [EXP_W-1:0] ne [2];
   logic [MAN_W-1:0] nm [2];
   logic             nz [2];
   logic [W-1:0]     bnd [2];

   assign bnd[0] = lo_i;
   assign bnd[1] = hi_i;

   for (genvar g = 0; g < 2; g++) begin : g_bound
      unint_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
         .exp_i (bnd[g][MAN_W +: EXP_W]),
         .man_i (bnd[g][MAN_W-1:0]),
         .fill_i(1'b0),
         .exp_o (ne[g]),
         .man_o (nm[g]),
         .zero_o(nz[g])
      );
   end

   logic [CW-1:0]    common;
   logic [CW-1:0]    drop;
   logic [EXP_W:0]   raised;
   logic             same_sign;
   logic [EXP_W-1:0] big_exp;

   unint_lzc #(.W(MAN_W)) u_prefix (.vec_i(nm[0] ^ nm[1]), .cnt_o(common));

   assign same_sign = (lo_i[W-1] == hi_i[W-1]);
   assign big_exp   = (ne[0] > ne[1]) ? ne[0] : ne[1];
   assign drop      = CW'(MAN_W) - common;
   assign raised    = {1'b0, ne[0]} + (EXP_W+1)'(drop);

   always_comb begin
      err_o = 1'b0;
      res_o = '0;
      if (same_sign && ({ne[0], nm[0]} > {ne[1], nm[1]})) begin
         err_o = 1'b1;
      end else if (nz[0] && nz[1]) begin
         res_o = '0;
      end else if (!same_sign) begin
         res_o = {1'b0, big_exp, {MAN_W{1'b0}}};
      end else if (ne[0] != ne[1]) begin
         res_o = {lo_i[W-1], big_exp, {MAN_W{1'b0}}};
      end else if (raised > (EXP_W+1)'(EMAX)) begin
         res_o = {lo_i[W-1], EXP_W'(EMAX), {MAN_W{1'b0}}};
      end else begin
         res_o = {lo_i[W-1], raised[EXP_W-1:0], nm[0] >> drop};
      end
   end
endmodule

// File: rtl/unorm_interval_conv.sv
module unorm_interval_conv
   import unint_pkg::*;
#(
   parameter  int EXP_W = 8,
   parameter  int MAN_W = 24,
   localparam int W     = 1 + EXP_W + MAN_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req_valid,
   input  logic         req_op,
   input  logic [W-1:0] req_word,
   input  logic [W-1:0] req_lo,
   input  logic [W-1:0] req_hi,
   output logic         res_valid,
   output logic [W-1:0] res_lo,
   output logic [W-1:0] res_hi,
   output logic         res_err
);
   if (EXP_W < 2 || MAN_W < 2) begin : g_bad_fmt
      $error("unorm_interval_conv: field widths too small");
   end

   // expand path: one normalizer per fill value
   logic [EXP_W-1:0] xe [2];
   logic [MAN_W-1:0] xm [2];
   logic             xz [2];
   logic [W-1:0]     xw [2];

   for (genvar f = 0; f < 2; f++) begin : g_fill
      unint_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
         .exp_i (req_word[MAN_W +: EXP_W]),
         .man_i (req_word[MAN_W-1:0]),
         .fill_i(f[0]),
         .exp_o (xe[f]),
         .man_o (xm[f]),
         .zero_o(xz[f])
      );
      assign xw[f] = xz[f] ? '0 : {req_word[W-1], xe[f], xm[f]};
   end

   // collapse path
   logic [W-1:0] cw;
   logic         cerr;

   unint_enclose #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_enclose (
      .lo_i (req_lo),
      .hi_i (req_hi),
      .res_o(cw),
      .err_o(cerr)
   );

   unint_op_e op;
   logic      last_op;
   assign op = unint_op_e'(req_op);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_lo    <= '0;
         res_hi    <= '0;
         res_err   <= 1'b0;
         last_op   <= 1'b0;
      end else begin
         res_valid <= req_valid;
         if (req_valid) begin
            last_op <= req_op;
            if (op == OP_EXPAND) begin
               res_lo  <= xw[0];
               res_hi  <= xw[1];
               res_err <= 1'b0;
            end else begin
               res_lo  <= cw;
               res_hi  <= '0;
               res_err <= cerr;
            end
         end
      end
   end

   // checks on the registered results
   logic [MAN_W-1:0] fill_diff;
   assign fill_diff = res_hi[MAN_W-1:0] ^ res_lo[MAN_W-1:0];

   p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid);
   p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_valid);
   p_fill_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && last_op == 1'b0) |->
         ((fill_diff & (fill_diff + 1'b1)) == '0) &&
         (res_hi[W-1:MAN_W] == res_lo[W-1:MAN_W]));
   p_expand_noerr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && last_op == 1'b0) |-> !res_err);
   p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      res_err |-> (res_lo == '0 && res_hi == '0));
   p_collapse_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && last_op == 1'b1) |-> res_hi == '0);
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(res_lo) && $stable(res_hi));
endmodule

// File: tb/unorm_interval_conv_tb.sv
`timescale 1ns/1ps
module unorm_interval_conv_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_op = 1'b0;
   logic [32:0] req_word = '0, req_lo = '0, req_hi = '0;
   logic        res_valid, res_err;
   logic [32:0] res_lo, res_hi;

   int total = 0, bad = 0;
   bit finished = 0;
   string cur_tag = "R9";

   always #4 clk = ~clk;

   unorm_interval_conv u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_word(req_word), .req_lo(req_lo), .req_hi(req_hi),
      .res_valid(res_valid), .res_lo(res_lo), .res_hi(res_hi), .res_err(res_err)
   );

   function automatic logic [32:0] m_norm(logic [32:0] w, bit fill);
      int e = int'(w[31:24]);
      longint m = longint'(w[23:0]);
      if (m == 0) return '0;
      while (m < 64'h800000 && e > 0) begin
         m = m * 2 + (fill ? 1 : 0);
         e--;
      end
      return {w[32], 8'(e), 24'(m)};
   endfunction

   function automatic logic [32:0] m_store(logic [32:0] lo, logic [32:0] hi, output bit err);
      logic [32:0] a = m_norm(lo, 0);
      logic [32:0] b = m_norm(hi, 0);
      int k, drop, e;
      err = 0;
      if (lo[32] == hi[32] && a[31:0] > b[31:0]) begin err = 1; return '0; end
      if (a[23:0] == 0 && b[23:0] == 0) return '0;
      e = (a[31:24] > b[31:24]) ? int'(a[31:24]) : int'(b[31:24]);
      if (lo[32] != hi[32]) return {1'b0, 8'(e), 24'd0};
      if (a[31:24] != b[31:24]) return {lo[32], 8'(e), 24'd0};
      k = 24;
      while (k > 0 && (a[23:0] >> (24 - k)) != (b[23:0] >> (24 - k))) k--;
      drop = 24 - k;
      if (e + drop > 255) return {lo[32], 8'd255, 24'd0};
      return {lo[32], 8'(e + drop), 24'(a[23:0] >> drop)};
   endfunction

   // reference model, one register deep
   logic        e_valid = 0, e_err = 0;
   logic [32:0] e_lo = '0, e_hi = '0;
   string       e_tag = "R9";

   always @(posedge clk) begin
      if (!rst_n) begin
         e_valid <= 0; e_lo <= '0; e_hi <= '0; e_err <= 0; e_tag <= "R9";
      end else begin
         e_valid <= req_valid;
         if (req_valid) begin
            e_tag <= cur_tag;
            if (!req_op) begin
               e_lo <= m_norm(req_word, 0);
               e_hi <= m_norm(req_word, 1);
               e_err <= 0;
            end else begin
               bit er;
               logic [32:0] r;
               r = m_store(req_lo, req_hi, er);
               e_lo <= r; e_hi <= '0; e_err <= er;
            end
         end
      end
   end

   task automatic chk(string tag, string what, logic [32:0] act, logic [32:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R9", "res_valid", 33'(res_valid), 33'(e_valid));
         chk(e_tag, "res_lo", res_lo, e_lo);
         chk(e_tag, "res_hi", res_hi, e_hi);
         chk(e_tag == "R7" ? "R7" : e_tag, "res_err", 33'(res_err), 33'(e_err));
      end
   end

   task automatic expand(string tag, logic [32:0] w);
      @(negedge clk);
      cur_tag = tag; req_valid = 1; req_op = 0; req_word = w;
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic collapse(string tag, logic [32:0] lo, logic [32:0] hi);
      @(negedge clk);
      cur_tag = tag; req_valid = 1; req_op = 1; req_lo = lo; req_hi = hi;
      @(negedge clk);
      req_valid = 0;
   endtask

   initial begin
      #(8 * 20000);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R9 reset state, checked directly
      chk("R9", "reset res_lo", res_lo, '0);
      chk("R9", "reset res_hi", res_hi, '0);
      chk("R9", "reset res_valid", 33'(res_valid), 33'd0);

      expand("R1", {1'b0, 8'd130, 24'h000F00});
      expand("R2", {1'b1, 8'd140, 24'h00A5C3});
      expand("R1", {1'b0, 8'd100, 24'h800001});
      expand("R2", {1'b0, 8'd3,   24'h000100});
      expand("R3", {1'b1, 8'd50,  24'h000000});
      repeat (2) @(negedge clk);               // R9 hold between requests
      collapse("R4", {1'b0, 8'd140, 24'hA00000}, {1'b0, 8'd140, 24'hA0FFFF});
      collapse("R4", {1'b1, 8'd129, 24'h00C000}, {1'b1, 8'd121, 24'hC10000});
      collapse("R5", {1'b0, 8'd135, 24'h9ABCDE}, {1'b0, 8'd135, 24'h9ABCDE});
      collapse("R5", 33'd0, 33'd0);
      collapse("R6", {1'b1, 8'd130, 24'h800000}, {1'b0, 8'd140, 24'h900000});
      collapse("R6", {1'b0, 8'd130, 24'h800000}, {1'b0, 8'd140, 24'h900000});
      collapse("R7", {1'b0, 8'd140, 24'hC00000}, {1'b0, 8'd140, 24'h800000});
      collapse("R7", {1'b1, 8'd150, 24'h800000}, {1'b1, 8'd140, 24'hF00000});
      collapse("R8", {1'b0, 8'd250, 24'h800000}, {1'b0, 8'd250, 24'h80FFFF});
      expand("R9", {1'b0, 8'd90, 24'h123456});

      for (int i = 0; i < 400; i++) begin
         logic [32:0] a, b, t;
         a = {1'($urandom), 8'($urandom), 24'($urandom >> ($urandom % 24))};
         if (i % 2 == 0) begin
            expand((i % 4 == 0) ? "R1" : "R2", a);
         end else begin
            b = a ^ 33'($urandom % (1 << ($urandom % 25)));
            if (i % 7 != 0 && m_norm(a, 0) > m_norm(b, 0) && a[32] == b[32]) begin
               t = a; a = b; b = t;
            end
            collapse("R4", a, b);
         end
      end
      repeat (2) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule